// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is a configurable two-level logic plane. Sixteen array inputs are each split into a true column and an inverted column, giving thirty-two columns. Sixty-four wide AND gates (product terms) each pick any subset of those columns through a per-crosspoint connection map. A fixed OR stage then sums eight consecutive product terms into each of eight outputs. Each product term also carries an enable bit, so an unused term drops out of its sum.

The connection map and the enable bits are written one term per cycle through a word-wide port. A small controller with three states governs when writes are allowed and when the outputs are valid. BLANK is the state after reset: nothing is loaded and outputs are invalid. LOAD accepts writes and freezes evaluation. RUN evaluates combinationally and raises `cfg_done`. The transitions are:
- START_FROM_BLANK: BLANK to LOAD on `load_start`.
- FINISH: LOAD to RUN on `load_end`.
- RELOAD: RUN to LOAD on `load_start`.
- HOLD: every state stays as it is when none of these conditions applies.

Top module: `sop_plane`

## Requirements
- R1: After reset `cfg_done` is 0 and `sum_out` is 0. Every term is cleared to no connections and disabled.
- R2: `load_start` moves BLANK or RUN to LOAD, and `cfg_done` is 0 from the next cycle. `load_end` while in LOAD moves to RUN, and `cfg_done` is 1 from the next cycle. In every other case the state is held.
- R3: While `cfg_done` is 0, `sum_out` is all zeros whatever `arr_in` is.
- R4: A write (`cfg_we` high) changes the stored configuration only in LOAD. Writes made in BLANK or RUN have no effect on any later output.
- R5: A write stores into term `cfg_addr` the connection map `cfg_mask` and the enable bit `cfg_en`. Mask bit 2i connects the true value of `arr_in[i]`, and mask bit 2i+1 connects its inverse.
- R6: In RUN, an enabled term is the AND of its connected columns. It follows `arr_in` combinationally, in the same cycle.
- R7: An enabled term with no connected columns evaluates to 1.
- R8: An enabled term that connects both columns of the same input evaluates to 0.
- R9: A disabled term contributes 0 to its sum, whatever its connections are.
- R10: `sum_out[k]` is the OR of terms 8k to 8k+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_start | input | 1 | Open a configuration session |
| load_end | input | 1 | Close the session and start evaluation |
| cfg_we | input | 1 | Write strobe for one term |
| cfg_addr | input | 6 | Index of the term to write |
| cfg_mask | input | 32 | Crosspoint map of that term |
| cfg_en | input | 1 | Enable bit of that term |
| arr_in | input | 16 | Array inputs |
| sum_out | output | 8 | OR sums, valid while cfg_done is 1 |
| cfg_done | output | 1 | High while evaluating in RUN |

## Verification
The bench covers four corner cases, and each has its own failure mode:
- Empty term: it must read 1. A design that reduces an empty AND to 0 loses this constant.
- Term with both columns of one input: it must read 0. A design that masks only one polarity would let it pass as 1.
- Disabled term: it must drop out of its sum. A design that ignores the enable bit would raise that output.
- Writes outside LOAD: they must be ignored. A design that accepts them would change results during RUN or after reset.

All 256 values of the low input byte are swept, and random sparse maps are compared against an arithmetic model. Together these catch wrong column polarity and wrong grouping of terms into outputs.

// File: rtl/sop_pkg.sv
package sop_pkg;
    parameter int N_IN  = 16;
    parameter int TPO   = 8;
    parameter int N_OUT = 8;
    localparam int N_COL  = 2 * N_IN;
    localparam int N_TERM = TPO * N_OUT;
    localparam int AW     = $clog2(N_TERM);

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl
    import sop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_start,
    input  logic load_end,
    output logic wr_open,
    output logic eval_on
);
    cfg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (load_start) state_d = ST_LOAD;   // START_FROM_BLANK
            ST_LOAD:  if (load_end)   state_d = ST_RUN;    // FINISH
            ST_RUN:   if (load_start) state_d = ST_LOAD;   // RELOAD
            default:  state_d = ST_BLANK;
        endcase
    end

    always_comb begin
        wr_open = 1'b0;
        eval_on = 1'b0;
        unique case (state_q)
            ST_BLANK: ;
            ST_LOAD:  wr_open = 1'b1;
            ST_RUN:   eval_on = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int N_COL  = 32,
    parameter int N_TERM = 64,
    parameter int AW     = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_open,
    input  logic                             cfg_we,
    input  logic [AW-1:0]                    cfg_addr,
    input  logic [N_COL-1:0]                 cfg_mask,
    input  logic                             cfg_en,
    output logic [N_TERM-1:0][N_COL-1:0]     conn,
    output logic [N_TERM-1:0]                term_on
);
    logic wr_ok;
    assign wr_ok = wr_open & cfg_we;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        assign hit = wr_ok && (int'(cfg_addr) == t);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                conn[t]    <= '0;
                term_on[t] <= 1'b0;
            end else if (hit) begin
                conn[t]    <= cfg_mask;
                term_on[t] <= cfg_en;
            end
        end
    end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 64,
    localparam int N_COL = 2 * N_IN
) (
    input  logic [N_IN-1:0]              arr_in,
    input  logic [N_TERM-1:0][N_COL-1:0] conn,
    input  logic [N_TERM-1:0]            term_on,
    output logic [N_TERM-1:0]            terms
);
    logic [N_COL-1:0] cols;

    for (genvar i = 0; i < N_IN; i++) begin : g_col
        assign cols[2*i]   = arr_in[i];
        assign cols[2*i+1] = ~arr_in[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_and
        assign terms[t] = term_on[t] & (&(~conn[t] | cols));
    end
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
    parameter int TPO   = 8,
    parameter int N_OUT = 8,
    localparam int N_TERM = TPO * N_OUT
) (
    input  logic [N_TERM-1:0] terms,
    output logic [N_OUT-1:0]  sums
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_or
        assign sums[k] = |terms[k*TPO +: TPO];
    end
endmodule

// File: rtl/sop_plane.sv
module sop_plane
    import sop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic              load_end,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [N_COL-1:0]  cfg_mask,
    input  logic              cfg_en,
    input  logic [N_IN-1:0]   arr_in,
    output logic [N_OUT-1:0]  sum_out,
    output logic              cfg_done
);
    logic                         wr_open;
    logic                         eval_on;
    logic [N_TERM-1:0][N_COL-1:0] conn;
    logic [N_TERM-1:0]            term_on;
    logic [N_TERM-1:0]            terms;
    logic [N_OUT-1:0]             sums;

    sop_cfg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_end(load_end),
        .wr_open(wr_open), .eval_on(eval_on)
    );

    sop_cfg_store #(.N_COL(N_COL), .N_TERM(N_TERM), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
        .conn(conn), .term_on(term_on)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .arr_in(arr_in), .conn(conn), .term_on(term_on), .terms(terms)
    );

    sop_or_group #(.TPO(TPO), .N_OUT(N_OUT)) u_or (
        .terms(terms), .sums(sums)
    );

    assign sum_out  = eval_on ? sums : '0;
    assign cfg_done = eval_on;
endmodule

// File: rtl/sop_plane_chk.sv
module sop_plane_chk
    import sop_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_start,
    input logic             load_end,
    input logic [N_IN-1:0]  arr_in,
    input logic [N_OUT-1:0] sum_out,
    input logic             cfg_done
);
    // R3
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (sum_out == '0));

    // R2
    reload_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && load_start) |=> !cfg_done);

    // R2
    done_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done && !load_end) |=> !cfg_done);

    // R4
    run_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && $past(cfg_done) && $stable(arr_in)) |-> $stable(sum_out));
endmodule

bind sop_plane sop_plane_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_end(load_end),
    .arr_in(arr_in), .sum_out(sum_out), .cfg_done(cfg_done)
);

// File: tb/sop_plane_tb.sv
`timescale 1ns/1ps
module sop_plane_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_start = 1'b0, load_end = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_mask = '0;
    logic [15:0] arr_in = '0;
    logic [7:0]  sum_out;
    logic        cfg_done;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_mask [64];
    bit          m_en   [64];

    always #2.5 clk = ~clk;

    sop_plane u_dut (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_end(load_end),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
        .arr_in(arr_in), .sum_out(sum_out), .cfg_done(cfg_done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_sum(logic [15:0] v);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 8; j++) begin
                int  t = 8 * k + j;
                bit  p = 1'b1;
                if (!m_en[t]) continue;
                for (int c = 0; c < 32; c++) begin
                    bit colv = (c % 2 == 0) ? v[c/2] : !v[c/2];
                    if (m_mask[t][c] && !colv) p = 1'b0;
                end
                if (p) r[k] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic wr(int t, logic [31:0] m, bit e, bit accepted);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(t); cfg_mask = m; cfg_en = e;
        @(negedge clk);
        cfg_we = 1'b0;
        if (accepted) begin m_mask[t] = m; m_en[t] = e; end
    endtask

    task automatic pulse_start();
        @(negedge clk); load_start = 1'b1;
        @(negedge clk); load_start = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); load_end = 1'b1;
        @(negedge clk); load_end = 1'b0;
    endtask

    task automatic apply(logic [15:0] v);
        @(negedge clk); arr_in = v; #1;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int t = 0; t < 64; t++) begin m_mask[t] = '0; m_en[t] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", 32'(cfg_done), 0);
        chk("R1 sum", 32'(sum_out), 0);

        // R4: write in BLANK is ignored (would make sum_out[0] high)
        wr(0, 32'h0, 1'b1, 1'b0);
        pulse_start();
        chk("R2 load clears done", 32'(cfg_done), 0);
        apply(16'hFFFF);
        chk("R3 sum zero while loading", 32'(sum_out), 0);
        pulse_end();
        chk("R2 done after end", 32'(cfg_done), 1);
        apply(16'h0000);
        chk("R4 blank write ignored", 32'(sum_out), 0);
        apply(16'h5A3C);
        chk("R1 cleared config", 32'(sum_out), 0);

        // Directed corner cases
        pulse_start();
        chk("R2 reload clears done", 32'(cfg_done), 0);
        wr(0,  32'h0, 1'b1, 1'b1);                 // R7 empty term
        wr(9,  32'h1 << 6, 1'b1, 1'b1);            // R5 true of input 3
        wr(17, 32'h1 << 7, 1'b1, 1'b1);            // R5 inverse of input 3
        wr(24, 32'h3 << 4, 1'b1, 1'b1);            // R8 both polarities of input 2
        wr(40, 32'h0, 1'b1, 1'b1);
        wr(40, 32'h0, 1'b0, 1'b1);                 // R9 disabled
        apply(16'hFFFF);
        chk("R3 sum zero in LOAD", 32'(sum_out), 0);
        pulse_end();
        for (int v = 0; v < 256; v++) begin
            apply(16'(v));
            chk("R7 empty term high", 32'(sum_out[0]), 1);
            chk("R5 true column", 32'(sum_out[1]), 32'(arr_in[3]));
            chk("R5 inverse column", 32'(sum_out[2]), 32'(!arr_in[3]));
            chk("R8 contradiction low", 32'(sum_out[3]), 0);
            chk("R9 disabled term", 32'(sum_out[5]), 0);
            chk("R6 R10 full compare", 32'(sum_out), 32'(ref_sum(arr_in)));
        end

        // R4: write in RUN ignored (would make sum_out[3] high)
        wr(24, 32'h0, 1'b1, 1'b0);
        apply(16'h1234);
        chk("R4 run write ignored", 32'(sum_out[3]), 0);

        // Random sparse configurations
        for (int r = 0; r < 4; r++) begin
            pulse_start();
            for (int t = 0; t < 64; t++)
                wr(t, $urandom & $urandom & $urandom & $urandom, ($urandom % 4) != 0, 1'b1);
            pulse_end();
            for (int n = 0; n < 200; n++) begin
                apply(16'($urandom));
                chk("R10 random compare", 32'(sum_out), 32'(ref_sum(arr_in)));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule